// File: doc/BRIEF.md
# NAND Page BCH Parity Checker

This block watches the byte stream of a NAND page read at boot. The main area of the page is split into 512-byte sectors. As each sector's bytes arrive, the block divides the sector by a fixed binary generator polynomial and keeps the remainder as that sector's parity word. The parity words are held in a small bank, so the next sector starts with no gap.

Once the main area has been read, the spare area follows. The block discards the bad-block marker bytes. It then walks one slot per sector, in sector order. Each slot holds the stored parity bytes and a closing pad byte. The block compares each stored byte with the held parity as it arrives, checks the pad byte, and reports a mismatch flag per sector, a page-level flag and a pad-violation flag. It does not locate or correct errors, and it has no path back toward the flash.

The page-size code sets three things: the sector count, the parity width (104 or 208 bits) and the slot length. The generator polynomials are parameters.

Top module: `nand_bch_page_check`

## Requirements
- R1: The parity of a sector is the remainder of (sector bits · x^P) modulo G. The sector is 512 bytes, fed first byte first and each byte most significant bit first. In size mode 00, P=104 and G is G_LO. In size mode 01, P=208 and G is G_HI. Each G is given without its leading x^P term. Each sector's parity starts from zero.
- R2: `page_size` is sampled on `page_start`. Code 00 selects a 2048-byte main area of 4 sectors, with 13 parity bytes and one pad byte per slot. Code 01 selects a 4096-byte main area of 8 sectors, with 26 parity bytes and one pad byte per slot. In mode 00, `sector_err[7:4]` stays 0.
- R3: The spare area starts with 2 marker bytes, which are ignored whatever their value. Then come the slots, in sector order. Within a slot, stored byte k is compared with parity bits P-1-8k down to P-8-8k, so the most significant byte comes first.
- R4: At `page_done`, `sector_err[i]` is 1 exactly when a stored parity byte of sector i differs from the computed parity, unless the sector is erased. `page_err` is the OR of all `sector_err` bits.
- R5: At `page_done`, `pad_err` is 1 when any non-erased sector's pad byte is not 0x00.
- R6: A sector whose 512 data bytes, parity bytes and pad byte are all 0xFF counts as erased. An erased sector reports no sector error and no pad error.
- R7: `page_done` is high for exactly one cycle. That cycle follows the clock edge that accepts the last pad byte. After it, `sector_err`, `pad_err` and `page_err` hold until the next `page_start`.
- R8: Bytes presented while `data_valid` is low are not consumed, and idle gaps change no result. Bytes that arrive after a page has completed are ignored.
- R9: A `page_start` with size code 10 or 11 sets `config_error` on the next cycle. While `config_error` is set, incoming bytes produce no `page_done` and the result flags stay 0. A later `page_start` with a supported code clears `config_error`.
- R10: `page_start` clears all result flags on the next cycle and abandons any page in progress. A byte presented in the same cycle as `page_start` is not consumed. All outputs are 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| page_start | input | 1 | Pulse that begins a new page |
| page_size | input | 2 | Page-size code, sampled with page_start |
| data_valid | input | 1 | data_in carries a page byte this cycle |
| data_in | input | 8 | Page byte: main area, then spare area |
| sector_err | output | MAX_SECTORS | Per-sector parity mismatch flags |
| page_err | output | 1 | Any sector flagged |
| pad_err | output | 1 | A non-erased slot had a nonzero pad byte |
| page_done | output | 1 | One-cycle pulse when results are final |
| config_error | output | 1 | Unsupported page-size code was given |

## Verification
The hardest case to reach from the ports is a sector whose parity check depends on the boundary. One example is a corrupted final data byte of a sector, where the remainder must be latched with that byte folded in. Another is a corrupted last parity byte of a slot, just before the pad. The bench builds whole pages from a bit-serial reference remainder, edits individual bytes at those boundary positions before sending, and recomputes the expected flags from the bytes actually sent. Erased and partly erased pages, random `data_valid` gaps and a restart in the middle of a page cover the remaining paths.

// File: rtl/nand_ecc_pkg.sv
package nand_ecc_pkg;
    typedef enum logic [2:0] {
        PH_IDLE = 3'd0,
        PH_MAIN = 3'd1,
        PH_MARK = 3'd2,
        PH_SLOT = 3'd3,
        PH_DONE = 3'd4
    } phase_e;

    localparam logic [1:0] SZ_2K = 2'b00;
    localparam logic [1:0] SZ_4K = 2'b01;
endpackage

// File: rtl/bch_byte_step.sv
// Advances the running remainder by one byte, most significant bit first.
module bch_byte_step #(
    parameter int PAR_LO = 104,
    parameter int PAR_HI = 208,
    parameter logic [PAR_LO-1:0] G_LO = '0,
    parameter logic [PAR_HI-1:0] G_HI = '0
) (
    input  logic [PAR_HI-1:0] cur,
    input  logic [7:0]        din,
    input  logic              wide,
    output logic [PAR_HI-1:0] nxt
);
    logic [PAR_LO-1:0] rem_lo;
    logic [PAR_HI-1:0] rem_hi;
    logic              fb;

    always_comb begin
        rem_lo = cur[PAR_LO-1:0];
        rem_hi = cur;
        fb     = 1'b0;
        if (wide) begin
            for (int i = 7; i >= 0; i--) begin
                fb     = din[i] ^ rem_hi[PAR_HI-1];
                rem_hi = {rem_hi[PAR_HI-2:0], 1'b0};
                if (fb) rem_hi = rem_hi ^ G_HI;
            end
            nxt = rem_hi;
        end else begin
            for (int i = 7; i >= 0; i--) begin
                fb     = din[i] ^ rem_lo[PAR_LO-1];
                rem_lo = {rem_lo[PAR_LO-2:0], 1'b0};
                if (fb) rem_lo = rem_lo ^ G_LO;
            end
            nxt = {{(PAR_HI-PAR_LO){1'b0}}, rem_lo};
        end
    end
endmodule

// File: rtl/ecc_parity_bank.sv
// Holds one left-justified parity word and an all-0xFF flag per sector.
module ecc_parity_bank #(
    parameter int DEPTH  = 8,
    parameter int PAR_W  = 208,
    parameter int IDX_W  = 3,
    parameter int SEL_W  = 5
) (
    input  logic             clk,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [PAR_W-1:0] wr_par,
    input  logic             wr_ff,
    input  logic [IDX_W-1:0] rd_idx,
    input  logic [SEL_W-1:0] rd_sel,
    output logic [7:0]       rd_byte,
    output logic             rd_ff
);
    logic [PAR_W-1:0] par_q [DEPTH];
    logic             ff_q  [DEPTH];
    logic [PAR_W-1:0] shifted;

    always_ff @(posedge clk) begin
        if (wr_en) begin
            par_q[wr_idx] <= wr_par;
            ff_q[wr_idx]  <= wr_ff;
        end
    end

    always_comb begin
        shifted = par_q[rd_idx] << {rd_sel, 3'b000};
        rd_byte = shifted[PAR_W-1 -: 8];
        rd_ff   = ff_q[rd_idx];
    end
endmodule

// File: rtl/nand_bch_page_check.sv
module nand_bch_page_check
    import nand_ecc_pkg::*;
#(
    parameter int SECTOR_BYTES = 512,
    parameter int MARK_BYTES   = 2,
    parameter int MAX_SECTORS  = 8,
    parameter int PAR_LO       = 104,
    parameter int PAR_HI       = 208,
    parameter logic [PAR_LO-1:0] G_LO = 104'h9F3A_61C5_D28E_47B0_1E6D_95A3_3B,
    parameter logic [PAR_HI-1:0] G_HI =
        208'hC3A5_0F96_7E21_B84D_5A3C_E017_92F4_6B8D_13E5_A07C_4D29_86FB_5E31
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   page_start,
    input  logic [1:0]             page_size,
    input  logic                   data_valid,
    input  logic [7:0]             data_in,
    output logic [MAX_SECTORS-1:0] sector_err,
    output logic                   page_err,
    output logic                   pad_err,
    output logic                   page_done,
    output logic                   config_error
);
    localparam int SB_W   = $clog2(SECTOR_BYTES);
    localparam int SEC_W  = $clog2(MAX_SECTORS);
    localparam int NB_LO  = PAR_LO / 8;
    localparam int NB_HI  = PAR_HI / 8;
    localparam int SLOT_W = $clog2(NB_HI + 1);
    localparam int MK_W   = $clog2(MARK_BYTES + 1);

    typedef struct packed {
        phase_e                 ph;
        logic                   wide;
        logic [SB_W-1:0]        bcnt;
        logic [SEC_W-1:0]       sec;
        logic [MK_W-1:0]        mcnt;
        logic [SLOT_W-1:0]      scnt;
        logic [PAR_HI-1:0]      crc;
        logic                   dff;
        logic                   mism;
        logic                   pff;
        logic [MAX_SECTORS-1:0] serr;
        logic                   pad;
        logic                   done;
        logic                   cfg;
    } st_t;

    st_t st_d, st_q;

    logic [PAR_HI-1:0] step_nxt;
    logic              wr_en_d;
    logic [PAR_HI-1:0] wr_par_d;
    logic              wr_ff_d;
    logic [7:0]        rd_byte;
    logic              rd_ff;
    logic [SEC_W-1:0]  last_sec;
    logic [SLOT_W-1:0] nb_par;
    logic              erased;

    bch_byte_step #(
        .PAR_LO(PAR_LO), .PAR_HI(PAR_HI), .G_LO(G_LO), .G_HI(G_HI)
    ) u_step (
        .cur (st_q.crc),
        .din (data_in),
        .wide(st_q.wide),
        .nxt (step_nxt)
    );

    ecc_parity_bank #(
        .DEPTH(MAX_SECTORS), .PAR_W(PAR_HI), .IDX_W(SEC_W), .SEL_W(SLOT_W)
    ) u_bank (
        .clk    (clk),
        .wr_en  (wr_en_d),
        .wr_idx (st_q.sec),
        .wr_par (wr_par_d),
        .wr_ff  (wr_ff_d),
        .rd_idx (st_q.sec),
        .rd_sel (st_q.scnt),
        .rd_byte(rd_byte),
        .rd_ff  (rd_ff)
    );

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        wr_en_d   = 1'b0;
        wr_ff_d   = st_q.dff & (data_in == 8'hFF);
        wr_par_d  = st_q.wide ? step_nxt : (step_nxt << (PAR_HI - PAR_LO));
        last_sec  = st_q.wide ? SEC_W'(MAX_SECTORS - 1) : SEC_W'(MAX_SECTORS / 2 - 1);
        nb_par    = st_q.wide ? SLOT_W'(NB_HI) : SLOT_W'(NB_LO);
        erased    = rd_ff & st_q.pff & (data_in == 8'hFF);

        if (page_start) begin
            st_d      = '0;
            st_d.dff  = 1'b1;
            st_d.pff  = 1'b1;
            if (page_size == SZ_2K || page_size == SZ_4K) begin
                st_d.ph   = PH_MAIN;
                st_d.wide = (page_size == SZ_4K);
            end else begin
                st_d.ph  = PH_IDLE;
                st_d.cfg = 1'b1;
            end
        end else if (data_valid) begin
            unique case (st_q.ph)
                PH_MAIN: begin
                    st_d.crc = step_nxt;
                    st_d.dff = wr_ff_d;
                    if (st_q.bcnt == SB_W'(SECTOR_BYTES - 1)) begin
                        wr_en_d   = 1'b1;
                        st_d.crc  = '0;
                        st_d.dff  = 1'b1;
                        st_d.bcnt = '0;
                        if (st_q.sec == last_sec) begin
                            st_d.sec  = '0;
                            st_d.mcnt = '0;
                            st_d.ph   = PH_MARK;
                        end else begin
                            st_d.sec = st_q.sec + 1'b1;
                        end
                    end else begin
                        st_d.bcnt = st_q.bcnt + 1'b1;
                    end
                end
                PH_MARK: begin
                    if (st_q.mcnt == MK_W'(MARK_BYTES - 1)) begin
                        st_d.ph   = PH_SLOT;
                        st_d.scnt = '0;
                        st_d.mism = 1'b0;
                        st_d.pff  = 1'b1;
                    end else begin
                        st_d.mcnt = st_q.mcnt + 1'b1;
                    end
                end
                PH_SLOT: begin
                    if (st_q.scnt < nb_par) begin
                        st_d.mism = st_q.mism | (data_in != rd_byte);
                        st_d.pff  = st_q.pff & (data_in == 8'hFF);
                        st_d.scnt = st_q.scnt + 1'b1;
                    end else begin
                        st_d.serr[st_q.sec] = ~erased & st_q.mism;
                        st_d.pad  = st_q.pad | (~erased & (data_in != 8'h00));
                        st_d.scnt = '0;
                        st_d.mism = 1'b0;
                        st_d.pff  = 1'b1;
                        if (st_q.sec == last_sec) begin
                            st_d.ph   = PH_DONE;
                            st_d.done = 1'b1;
                        end else begin
                            st_d.sec = st_q.sec + 1'b1;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sector_err   = st_q.serr;
    assign page_err     = |st_q.serr;
    assign pad_err      = st_q.pad;
    assign page_done    = st_q.done;
    assign config_error = st_q.cfg;
endmodule

// File: rtl/nand_bch_page_check_sva.sv
module nand_bch_page_check_sva #(
    parameter int MAX_SECTORS = 8
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   page_start,
    input logic [1:0]             page_size,
    input logic [MAX_SECTORS-1:0] sector_err,
    input logic                   pad_err,
    input logic                   page_done,
    input logic                   config_error
);
    logic done_seen_q;
    logic wide_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done_seen_q <= 1'b0;
            wide_q      <= 1'b0;
        end else if (page_start) begin
            done_seen_q <= 1'b0;
            wide_q      <= (page_size == 2'b01);
        end else if (page_done) begin
            done_seen_q <= 1'b1;
        end
    end

    a_r7_done_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        page_done |=> !page_done);

    a_r7_hold_after_done: assert property (@(posedge clk) disable iff (!rst_n)
        (done_seen_q && !page_start) |=> ($stable(sector_err) && $stable(pad_err)));

    a_r9_cfg_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        config_error |-> (!page_done && sector_err == '0 && !pad_err));

    a_r9_cfg_follows_code: assert property (@(posedge clk) disable iff (!rst_n)
        (page_start && page_size[1]) |=> config_error);

    a_r10_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
        page_start |=> (sector_err == '0 && !pad_err && !page_done));

    a_r2_upper_idle_narrow: assert property (@(posedge clk) disable iff (!rst_n)
        !wide_q |-> (sector_err[MAX_SECTORS-1:MAX_SECTORS/2] == '0));
endmodule

bind nand_bch_page_check nand_bch_page_check_sva #(.MAX_SECTORS(MAX_SECTORS)) u_sva (
    .clk         (clk),
    .rst_n       (rst_n),
    .page_start  (page_start),
    .page_size   (page_size),
    .sector_err  (sector_err),
    .pad_err     (pad_err),
    .page_done   (page_done),
    .config_error(config_error)
);

// File: tb/nand_bch_page_check_bench.sv
module nand_bch_page_check_bench;
    localparam logic [103:0] G8  = 104'h9F3A_61C5_D28E_47B0_1E6D_95A3_3B;
    localparam logic [207:0] G16 =
        208'hC3A5_0F96_7E21_B84D_5A3C_E017_92F4_6B8D_13E5_A07C_4D29_86FB_5E31;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       page_start = 1'b0;
    logic [1:0] page_size = 2'b00;
    logic       data_valid = 1'b0;
    logic [7:0] data_in = 8'h00;
    logic [7:0] sector_err;
    logic       page_err, pad_err, page_done, config_error;

    always #10 clk = ~clk;

    nand_bch_page_check #(.G_LO(G8), .G_HI(G16)) u_nand_bch_page_check (
        .clk(clk), .rst_n(rst_n), .page_start(page_start), .page_size(page_size),
        .data_valid(data_valid), .data_in(data_in), .sector_err(sector_err),
        .page_err(page_err), .pad_err(pad_err), .page_done(page_done),
        .config_error(config_error)
    );

    typedef struct {
        logic [7:0] err;
        logic       pad;
        string      tag;
    } exp_t;

    exp_t       sb[$];
    int         n_total = 0;
    int         n_pass  = 0;
    logic [7:0] pg [4096];
    logic [7:0] oob [224];
    exp_t       last_exp;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_total++;
        if (ok) n_pass++;
        else $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    endtask

    function automatic logic [207:0] ref_par(input int s, input bit wide);
        logic [207:0] r;
        logic [207:0] g;
        int deg;
        logic fb;
        logic [7:0] b;
        r = '0;
        g = wide ? G16 : {104'b0, G8};
        deg = wide ? 208 : 104;
        for (int j = 0; j < 512; j++) begin
            b = pg[s*512 + j];
            for (int i = 7; i >= 0; i--) begin
                fb = b[i] ^ r[deg-1];
                r = r << 1;
                if (!wide) r[207:104] = '0;
                if (fb) r = r ^ g;
            end
        end
        return wide ? r : (r << 104);
    endfunction

    function automatic int nsec(input bit wide); return wide ? 8 : 4; endfunction
    function automatic int nbyt(input bit wide); return wide ? 26 : 13; endfunction

    task automatic fill_data(input bit wide, input bit all_ff);
        for (int j = 0; j < nsec(wide)*512; j++) pg[j] = all_ff ? 8'hFF : 8'($urandom);
    endtask

    task automatic make_oob(input bit wide);
        logic [207:0] p;
        int slot;
        slot = nbyt(wide) + 1;
        oob[0] = 8'h00;
        oob[1] = 8'h5A;
        for (int s = 0; s < nsec(wide); s++) begin
            p = ref_par(s, wide);
            for (int k = 0; k < nbyt(wide); k++) oob[2 + s*slot + k] = p[207-8*k -: 8];
            oob[2 + s*slot + nbyt(wide)] = 8'h00;
        end
    endtask

    function automatic exp_t model(input bit wide, input string tag);
        exp_t e;
        logic [207:0] p;
        int slot, base;
        bit mism, pff, dff, er;
        e.err = '0; e.pad = 1'b0; e.tag = tag;
        slot = nbyt(wide) + 1;
        for (int s = 0; s < nsec(wide); s++) begin
            p = ref_par(s, wide);
            base = 2 + s*slot;
            mism = 0; pff = 1; dff = 1;
            for (int j = 0; j < 512; j++) if (pg[s*512+j] != 8'hFF) dff = 0;
            for (int k = 0; k < nbyt(wide); k++) begin
                if (oob[base+k] != p[207-8*k -: 8]) mism = 1;
                if (oob[base+k] != 8'hFF) pff = 0;
            end
            er = dff && pff && (oob[base+nbyt(wide)] == 8'hFF);
            e.err[s] = !er && mism;
            if (!er && oob[base+nbyt(wide)] != 8'h00) e.pad = 1'b1;
        end
        return e;
    endfunction

    task automatic start_page(input logic [1:0] sz);
        @(negedge clk);
        page_start = 1'b1; page_size = sz; data_valid = 1'b1; data_in = 8'hFF;
        @(negedge clk);
        page_start = 1'b0; data_valid = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] b, input bit gaps);
        if (gaps && ($urandom % 3 == 0)) begin
            @(negedge clk);
            data_valid = 1'b0; data_in = 8'h3C;
        end
        @(negedge clk);
        data_valid = 1'b1; data_in = b;
    endtask

    task automatic run_page(input bit wide, input bit gaps, input string tag);
        exp_t e;
        e = model(wide, tag);
        sb.push_back(e);
        last_exp = e;
        start_page(wide ? 2'b01 : 2'b00);
        for (int j = 0; j < nsec(wide)*512; j++) send_byte(pg[j], gaps);
        for (int j = 0; j < 2 + nsec(wide)*(nbyt(wide)+1); j++) send_byte(oob[j], gaps);
        @(negedge clk);
        data_valid = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    // monitor: pops the scoreboard on every completion pulse
    initial begin
        exp_t e;
        forever begin
            @(negedge clk);
            if (rst_n && page_done) begin
                if (sb.size() == 0) begin
                    chk(0, "R9 unexpected page_done", 1, 0);
                end else begin
                    e = sb.pop_front();
                    chk(sector_err == e.err, {"R4 sector_err ", e.tag}, sector_err, e.err);
                    chk(pad_err == e.pad, {"R5 pad_err ", e.tag}, pad_err, e.pad);
                    chk(page_err == (e.err != 0), {"R4 page_err ", e.tag}, page_err, e.err != 0);
                    @(negedge clk);
                    chk(!page_done, {"R7 pulse width ", e.tag}, page_done, 0);
                end
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        chk(0, "watchdog", 0, 1);
        $display("%0d/%0d checks passed", n_pass, n_total);
        $finish;
    end

    initial begin
        logic [7:0] hold_err;
        logic hold_pad;
        repeat (3) @(negedge clk);
        chk(sector_err == 0 && !pad_err && !page_done && !config_error && !page_err,
            "R10 reset outputs", {sector_err, pad_err, page_done, config_error}, 0);
        rst_n = 1'b1;

        // R1 R2 R3: clean narrow page, marker bytes arbitrary
        fill_data(0, 0); make_oob(0);
        run_page(0, 0, "R1 clean 2k");

        // R3 R4: last parity byte of sector 2 corrupted
        oob[2 + 2*14 + 12] ^= 8'h01;
        run_page(0, 0, "R3 slot2 last parity byte");

        // R1 R4: data corrupted at sector boundaries
        fill_data(0, 0); make_oob(0);
        pg[0] ^= 8'h80; pg[4*512-1] ^= 8'h01;
        run_page(0, 0, "R1 data first/last byte");

        // R5: nonzero pad on sector 1
        fill_data(0, 0); make_oob(0);
        oob[2 + 1*14 + 13] = 8'h40;
        run_page(0, 0, "R5 pad sector1");

        // R6: fully erased page
        fill_data(0, 1);
        for (int j = 0; j < 224; j++) oob[j] = 8'hFF;
        run_page(0, 0, "R6 erased page");

        // R6: ff data with real parity on 0,1; erased slots on 2,3
        fill_data(0, 1); make_oob(0);
        for (int j = 2 + 2*14; j < 2 + 4*14; j++) oob[j] = 8'hFF;
        run_page(0, 0, "R6 partly erased");

        // R8: random gaps, error in sector 1
        fill_data(0, 0); make_oob(0);
        pg[512 + 77] ^= 8'h10;
        run_page(0, 1, "R8 gaps");

        // R2: wide page clean, then errors in sectors 4 and 7
        fill_data(1, 0); make_oob(1);
        run_page(1, 0, "R2 clean 4k");
        oob[2 + 4*27 + 25] ^= 8'h04;
        pg[7*512 + 300] ^= 8'h02;
        run_page(1, 1, "R2 4k sectors 4 7");

        // R8: junk after completion ignored
        hold_err = sector_err; hold_pad = pad_err;
        for (int j = 0; j < 40; j++) send_byte(8'($urandom), 0);
        @(negedge clk); data_valid = 1'b0;
        @(negedge clk);
        chk(sector_err == hold_err && pad_err == hold_pad && sector_err == last_exp.err,
            "R8 bytes after done", sector_err, last_exp.err);

        // R10: start clears flags
        start_page(2'b00);
        chk(sector_err == 0 && !pad_err, "R10 start clears", sector_err, 0);

        // R9: unsupported code
        start_page(2'b10);
        chk(config_error, "R9 config_error set", config_error, 1);
        for (int j = 0; j < 3000; j++) send_byte(8'($urandom), 0);
        @(negedge clk); data_valid = 1'b0;
        @(negedge clk);
        chk(config_error && sector_err == 0 && !pad_err, "R9 quiet under config error",
            {config_error, sector_err, pad_err}, 10'h200);
        start_page(2'b11);
        chk(config_error, "R9 code 11", config_error, 1);

        // R10: restart mid page, clears config_error too
        fill_data(0, 0); make_oob(0);
        start_page(2'b00);
        chk(!config_error, "R9 config_error cleared", config_error, 0);
        for (int j = 0; j < 300; j++) send_byte(8'($urandom), 0);
        run_page(0, 0, "R10 restart mid page");

        chk(sb.size() == 0, "R7 all pages completed", sb.size(), 0);
        $display("%0d/%0d checks passed", n_pass, n_total);
        $finish;
    end
endmodule